// File: doc/BRIEF.md
# PHY Management Register Responder

This block is a single memory-mapped management register that answers on behalf of an attached Ethernet PHY. Software writes a command word into the register. The word holds a combined PHY and register address and a read opcode. When software later reads the same register, the block returns a canned PHY answer. The answer carries a valid flag in bit 27 and, for the known PHY registers, a fixed 16-bit value.

The answer comes at once from a small parameterised table. No serial management transfer takes place. The table holds three entries by default. The status register reports link up and autonegotiation able, and two registers hold the two halves of the PHY identifier. The register bus is a plain 32-bit word port with one shared address, a write strobe and a read strobe. Read data is registered and appears in the cycle after the read strobe.

Top module: `mgmt_phy_responder`

## Requirements
- R1: A synchronous active-high reset clears the stored command and the read data to zero, and both hold zero in the first cycle after reset is released.
- R2: A write with `bus_addr` equal to the register offset (default 0x010) stores all 32 bits of `wr_data` as the command. A write to any other address leaves the stored command unchanged.
- R3: `rd_data` holds the answer in the cycle after a cycle with `rd_en` high. In the cycle after a cycle with `rd_en` low, `rd_data` is zero.
- R4: A read of the register while bit 26 (read opcode) of the stored command is 0 returns zero. This holds even if bit 27 or the address bits of the command are set.
- R5: With bit 26 set and command bits 25:16 equal to 0x021, a read returns 0x0800_000C.
- R6: With bit 26 set, command bits 25:16 equal to 0x041 return 0x0800_0141, and 0x061 return 0x0800_0E20.
- R7: With bit 26 set and any other value in bits 25:16, a read returns 0x0800_0000. Command bits 15:0 never affect any answer.
- R8: A read with `rd_en` high at any address other than the register offset returns zero.
- R9: Repeated reads return the same answer until a new command is written.
- R10: When a write and a read hit the register in the same cycle, the read returns the answer for the command stored before that write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W (12) | Byte address shared by reads and writes |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 32 | Registered read data, valid the cycle after `rd_en` |

## Verification
On every cycle, the in-RTL assertions check four things: the command holds steady unless a write hits the register, read data is zero after idle cycles and after reads of other addresses, a clear opcode yields zero, and a set opcode always raises the valid flag. The exact 16-bit table values, the fact that command data bits are ignored, the old-command answer when a write and a read share a cycle, and recovery from a reset in the middle of a run can only be shown by the bench scenarios. The bench shows them by comparing against its cycle model and against written-out constants.

// File: rtl/mgmt_pkg.sv
package mgmt_pkg;
  localparam int WORD_W      = 32;
  localparam int DATA_LO     = 0;
  localparam int DATA_W      = 16;
  localparam int PADDR_LO    = 16;
  localparam int PADDR_W     = 10;
  localparam int OPCODE_BIT  = 26;
  localparam int VALID_BIT   = 27;
endpackage

// File: rtl/mgmt_cmd_reg.sv
module mgmt_cmd_reg
  import mgmt_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] REG_OFFSET = 12'h010
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  output logic [WORD_W-1:0] cmd_q
);
  logic wr_hit;
  assign wr_hit = wr_en && (bus_addr == REG_OFFSET);

  always_ff @(posedge clk) begin
    if (rst)
      cmd_q <= '0;
    else if (wr_hit)
      cmd_q <= wr_data;
  end

  AST_CMD_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && (bus_addr == REG_OFFSET)) |=> $stable(cmd_q)); // R2
  AST_CMD_LOAD: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (bus_addr == REG_OFFSET)) |=> (cmd_q == $past(wr_data))); // R2
endmodule

// File: rtl/mgmt_phy_table.sv
module mgmt_phy_table
  import mgmt_pkg::*;
#(
  parameter int N_ENTRIES = 3,
  parameter logic [N_ENTRIES*PADDR_W-1:0] ENTRY_ADDRS = {10'h061, 10'h041, 10'h021},
  parameter logic [N_ENTRIES*DATA_W-1:0]  ENTRY_DATA  = {16'h0E20, 16'h0141, 16'h000C}
) (
  input  logic [WORD_W-1:0] cmd,
  output logic [WORD_W-1:0] resp
);
  logic [PADDR_W-1:0]   req_addr;
  logic [N_ENTRIES-1:0] hit;
  logic [DATA_W-1:0]    sel_data [N_ENTRIES];
  logic [DATA_W-1:0]    merged;
  logic                 opcode;

  assign req_addr = cmd[PADDR_LO +: PADDR_W];
  assign opcode   = cmd[OPCODE_BIT];

  for (genvar g = 0; g < N_ENTRIES; g++) begin : g_entry
    assign hit[g]      = (req_addr == ENTRY_ADDRS[g*PADDR_W +: PADDR_W]);
    assign sel_data[g] = hit[g] ? ENTRY_DATA[g*DATA_W +: DATA_W] : '0;
  end

  always_comb begin
    merged = '0;
    for (int i = 0; i < N_ENTRIES; i++)
      merged = merged | sel_data[i];
  end

  always_comb begin
    resp = '0;
    if (opcode) begin
      resp[VALID_BIT]               = 1'b1;
      resp[DATA_LO +: DATA_W]       = merged;
    end
  end
endmodule

// File: rtl/mgmt_phy_responder.sv
module mgmt_phy_responder
  import mgmt_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] REG_OFFSET = 12'h010,
  parameter int N_ENTRIES = 3,
  parameter logic [N_ENTRIES*PADDR_W-1:0] ENTRY_ADDRS = {10'h061, 10'h041, 10'h021},
  parameter logic [N_ENTRIES*DATA_W-1:0]  ENTRY_DATA  = {16'h0E20, 16'h0141, 16'h000C}
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              wr_en,
  input  logic [31:0]       wr_data,
  input  logic              rd_en,
  output logic [31:0]       rd_data
);
  logic [WORD_W-1:0] cmd_q;
  logic [WORD_W-1:0] resp;
  logic              rd_hit;

  mgmt_cmd_reg #(
    .ADDR_W     (ADDR_W),
    .REG_OFFSET (REG_OFFSET)
  ) u_cmd (
    .clk      (clk),
    .rst      (rst),
    .bus_addr (bus_addr),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .cmd_q    (cmd_q)
  );

  mgmt_phy_table #(
    .N_ENTRIES   (N_ENTRIES),
    .ENTRY_ADDRS (ENTRY_ADDRS),
    .ENTRY_DATA  (ENTRY_DATA)
  ) u_table (
    .cmd  (cmd_q),
    .resp (resp)
  );

  assign rd_hit = rd_en && (bus_addr == REG_OFFSET);

  always_ff @(posedge clk) begin
    if (rst)
      rd_data <= '0;
    else if (rd_hit)
      rd_data <= resp;
    else
      rd_data <= '0;
  end

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (rd_data == '0 && cmd_q == '0)); // R1
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> (rd_data == '0)); // R3
  AST_NO_OPCODE: assert property (@(posedge clk) disable iff (rst)
    (rd_en && bus_addr == REG_OFFSET && !cmd_q[OPCODE_BIT]) |=> (rd_data == '0)); // R4
  AST_VALID_FLAG: assert property (@(posedge clk) disable iff (rst)
    (rd_en && bus_addr == REG_OFFSET && cmd_q[OPCODE_BIT]) |=> rd_data[VALID_BIT]); // R7
  AST_OFF_ADDR: assert property (@(posedge clk) disable iff (rst)
    (rd_en && bus_addr != REG_OFFSET) |=> (rd_data == '0)); // R8
endmodule

// File: tb/tb_mgmt_phy_responder.sv
`timescale 1ns/1ps
module tb_mgmt_phy_responder;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] bus_addr = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [31:0] rd_data;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [31:0] ref_cmd = '0;
  logic [31:0] exp_rd  = '0;

  always #2 clk = ~clk;

  mgmt_phy_responder dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .wr_en(wr_en),
    .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data)
  );

  function automatic logic [31:0] answer(input logic [31:0] c);
    if (!c[26]) return 32'h0;
    case (c[25:16])
      10'h021: return 32'h0800_000C;
      10'h041: return 32'h0800_0141;
      10'h061: return 32'h0800_0E20;
      default: return 32'h0800_0000;
    endcase
  endfunction

  // Cycle model: inputs are stable at the rising edge
  always @(posedge clk) begin
    if (rst) begin
      ref_cmd = '0;
      exp_rd  = '0;
    end else begin
      exp_rd = (rd_en && bus_addr == 12'h010) ? answer(ref_cmd) : 32'h0;
      if (wr_en && bus_addr == 12'h010) ref_cmd = wr_data;
    end
  end

  // Compare on every clock (R3 timing, all answers)
  always @(negedge clk) begin
    if (!done) begin
      checks++;
      if (rd_data !== exp_rd) begin
        failures++;
        $display("FAIL R3 model compare t=%0t actual=%h expected=%h", $time, rd_data, exp_rd);
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    bus_addr = a; wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string req);
    bus_addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    chk(req, rd_data, exp);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk("R1 reset rd_data", rd_data, 32'h0);
        rd(12'h010, 32'h0, "R1 command cleared by reset");
        rd(12'h010, 32'h0, "R4 opcode clear after reset");
        wr(12'h010, 32'h0421_0000);
        rd(12'h010, 32'h0800_000C, "R5 status register");
        @(negedge clk);
        chk("R3 idle cycle gives zero", rd_data, 32'h0);
        wr(12'h010, 32'h0441_0000);
        rd(12'h010, 32'h0800_0141, "R6 identifier high");
        wr(12'h010, 32'h0461_FFFF);
        rd(12'h010, 32'h0800_0E20, "R6 identifier low, data bits ignored");
        wr(12'h010, 32'h0421_ABCD);
        rd(12'h010, 32'h0800_000C, "R7 data bits ignored");
        wr(12'h010, 32'h047F_0000);
        rd(12'h010, 32'h0800_0000, "R7 unknown address");
        wr(12'h010, 32'h0400_0000);
        rd(12'h010, 32'h0800_0000, "R7 address zero");
        wr(12'h010, 32'h0821_1234);
        rd(12'h010, 32'h0, "R4 valid bit written, opcode clear");
        wr(12'h010, 32'h0421_0000);
        wr(12'h014, 32'h0441_0000);
        rd(12'h010, 32'h0800_000C, "R2 write to other address ignored");
        wr(12'h000, 32'h0000_0000);
        rd(12'h010, 32'h0800_000C, "R2 write to address 0 ignored");
        rd(12'h014, 32'h0, "R8 read of other address");
        rd(12'h410, 32'h0, "R8 read of aliased high address");
        for (int k = 0; k < 4; k++)
          rd(12'h010, 32'h0800_000C, "R9 repeated read");
        // R10: write and read in the same cycle
        bus_addr = 12'h010; wr_en = 1'b1; wr_data = 32'h0461_0000; rd_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        chk("R10 read sees old command", rd_data, 32'h0800_000C);
        rd(12'h010, 32'h0800_0E20, "R10 new command after overlap");
        // R1: reset in the middle of a run
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R1 mid-run reset rd_data", rd_data, 32'h0);
        rd(12'h010, 32'h0, "R1 mid-run reset clears command");
        repeat (2) @(negedge clk);
      end
      begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
      end
    join_any
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule